// File: doc/BRIEF.md
# Boot Image Bit Streamer

This block sends a stored boot image one bit at a time on a single data line while a host runs a boot handshake. A separate frame detector decodes the host's commands and passes them in as a strobe and a two-bit code. The block keeps the image in an internal ROM. Each image byte already holds the acknowledge pattern, the block framing and the check bits, so every byte leaves the block unchanged. Bits go out most significant first. The output moves forward by one bit on each host-clock tick and at no other time. The host can only slow the transfer down by pausing its clock.

A state machine has four states: `ST_OFF`, `ST_WAIT`, `ST_SEND` and `ST_DONE`. Its transitions are:
- **enable** (`ST_OFF` to `ST_WAIT`): `en_i` rises.
- **start** (`ST_WAIT` to `ST_SEND`): a boot command arrives.
- **abort** (`ST_SEND` to `ST_WAIT`): a reset-idle command or a pre-idle command arrives.
- **finish** (`ST_SEND` to `ST_DONE`): the last bit of the image has been ticked out.
- **clear** (`ST_DONE` to `ST_WAIT`): a reset-idle command or a pre-idle command arrives.
- **disable** (any state to `ST_OFF`): `en_i` is low.

The data line stays high in every state except `ST_SEND`. Separately, a deadline counter starts when the block is enabled. It raises `timeout_o` if the block stays enabled for the configured time, which is 5 s by default.

Top module: `boot_streamer_ctrl`

## Requirements
- R1: After reset, `dat_o` is 1, `done_o` is 0 and `timeout_o` is 0.
- R2: In `ST_WAIT`, command codes 2'b01 (reset-idle), 2'b10 (pre-idle) and 2'b00 (unrecognised) leave `dat_o` at 1. Any code with `cmd_valid_i` low also leaves `dat_o` at 1. Only code 2'b11 (boot) starts streaming.
- R3: In the cycle after the block accepts a boot command, `dat_o` carries bit 7 of image byte 0. Each cycle with `bit_tick_i` high moves `dat_o` on by one bit, most significant first. Without a tick, `dat_o` holds its value.
- R4: Image byte k is ((k*29) mod 256) XOR 8'hC3. The bytes go out in order k = 0 .. IMG_BYTES-1, unchanged.
- R5: After IMG_BYTES*8 ticks, `done_o` is 1 and `dat_o` is 1. After that, further ticks and boot commands change neither output.
- R6: In `ST_SEND`, code 2'b01 or 2'b10 aborts the transfer, and `dat_o` is 1 from the next cycle. A later boot command restarts from bit 7 of byte 0.
- R7: In `ST_DONE`, code 2'b01 or 2'b10 clears `done_o`. A later boot command then streams the image again from byte 0.
- R8: When `en_i` is low, the next cycle has `dat_o` at 1 and `done_o` at 0. Streaming stops, and commands are ignored until `en_i` is high again.
- R9: `timeout_o` rises after `en_i` has been high for DEADLINE_MS milliseconds of clock edges. The count is CLK_HZ*DEADLINE_MS/1000 edges. `timeout_o` stays high while `en_i` stays high. It clears one edge after `en_i` goes low, and the count then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables the block: arms it for streaming and runs the deadline counter |
| cmd_valid_i | input | 1 | One-cycle strobe showing that a decoded command is present |
| cmd_code_i | input | 2 | 01 reset-idle, 10 pre-idle, 11 boot, 00 unrecognised |
| bit_tick_i | input | 1 | One-cycle pulse for each host clock; moves the output on by one bit |
| dat_o | output | 1 | Serial data line; 1 when idle |
| done_o | output | 1 | Set once the whole image has been sent |
| timeout_o | output | 1 | Boot deadline has expired while the block is enabled |

## Verification
The bench builds the block with a 2-byte image, CLK_HZ = 1000 and DEADLINE_MS = 200. With these values the full image fits in 16 ticks, so the bench can compare every bit. The bench can also reach the finish transition, clear it, and restart more than once. The 200-edge deadline lets the bench check the exact edge on which `timeout_o` rises, and that it clears when the block is disabled.

// File: rtl/boot_streamer_pkg.sv
package boot_streamer_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_IDLE    = 2'b01,
        CMD_PREIDLE = 2'b10,
        CMD_BOOT    = 2'b11
    } bs_cmd_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_DONE = 2'd3
    } bs_state_e;

    localparam logic [7:0] IMG_SEED = 8'hC3;
    localparam int unsigned IMG_STEP = 29;

endpackage

// File: rtl/boot_image_rom.sv
module boot_image_rom
    import boot_streamer_pkg::*;
#(
    parameter int unsigned IMG_BYTES = 64,
    parameter int unsigned IDX_W     = 6
) (
    input  logic [IDX_W-1:0] addr_i,
    output logic [7:0]       data_o
);
    // The image is computed from the byte index, not stored as a table.
    logic [31:0] prod;

    always_comb begin
        prod   = 32'(addr_i) * 32'(IMG_STEP);
        data_o = prod[7:0] ^ IMG_SEED;
    end

    initial begin
        if (IMG_BYTES == 0) $error("IMG_BYTES must be nonzero");
    end
endmodule

// File: rtl/boot_bit_shifter.sv
module boot_bit_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] byte_i,
    output logic         bit_o,
    output logic         last_o
);
    localparam int unsigned CNT_W = $clog2(W);

    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sreg <= '1;
            cnt  <= '0;
        end else if (load_i) begin
            sreg <= byte_i;
            cnt  <= '0;
        end else if (shift_i) begin
            if (cnt == CNT_W'(W - 1)) begin
                sreg <= byte_i;
                cnt  <= '0;
            end else begin
                sreg <= {sreg[W-2:0], 1'b1};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    assign bit_o  = sreg[W-1];
    assign last_o = (cnt == CNT_W'(W - 1));

    // R3: within a byte, each shift brings forward the next lower bit
    a_r3_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i && !last_o) |=> (bit_o == $past(sreg[W-2])));
endmodule

// File: rtl/boot_deadline_timer.sv
module boot_deadline_timer #(
    parameter longint unsigned LIMIT_CYC = 64'd500_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic timeout_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt <= '0;
        else if (!en_i)
            cnt <= '0;
        else if (cnt != CNT_W'(LIMIT_CYC))
            cnt <= cnt + 1'b1;
    end

    assign timeout_o = (cnt == CNT_W'(LIMIT_CYC));

    // R9: disabling clears the flag at the next edge
    a_r9_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !timeout_o);
    // R9: the flag holds while the block stays enabled
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && timeout_o) |=> timeout_o);
endmodule

// File: rtl/boot_streamer_ctrl.sv
module boot_streamer_ctrl
    import boot_streamer_pkg::*;
#(
    parameter int unsigned IMG_BYTES   = 64,
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned DEADLINE_MS = 5000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_code_i,
    input  logic       bit_tick_i,
    output logic       dat_o,
    output logic       done_o,
    output logic       timeout_o
);
    localparam int unsigned     IDX_W     = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;
    localparam longint unsigned LIMIT_CYC =
        (longint'(CLK_HZ) * longint'(DEADLINE_MS)) / 64'd1000;

    bs_state_e        state, nxt_state;
    bs_cmd_e          cmd;
    logic             is_idle, is_boot;
    logic             sh_load, sh_shift, sh_bit, sh_last;
    logic [IDX_W-1:0] byte_idx, rom_addr;
    logic [7:0]       rom_data;
    logic             img_end;

    assign cmd     = bs_cmd_e'(cmd_code_i);
    assign is_idle = cmd_valid_i && ((cmd == CMD_IDLE) || (cmd == CMD_PREIDLE));
    assign is_boot = cmd_valid_i && (cmd == CMD_BOOT);
    assign img_end = sh_last && (byte_idx == IDX_W'(IMG_BYTES - 1));

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_OFF:  if (en_i) nxt_state = ST_WAIT;
            ST_WAIT: if (is_boot) nxt_state = ST_SEND;
            ST_SEND: begin
                if (is_idle)
                    nxt_state = ST_WAIT;
                else if (bit_tick_i && img_end)
                    nxt_state = ST_DONE;
            end
            ST_DONE: if (is_idle) nxt_state = ST_WAIT;
            default: nxt_state = ST_OFF;
        endcase
        if (!en_i) nxt_state = ST_OFF;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= ST_OFF;
        else         state <= nxt_state;
    end

    // datapath control
    assign sh_load  = en_i && (state == ST_WAIT) && is_boot;
    assign sh_shift = en_i && (state == ST_SEND) && !is_idle && bit_tick_i;
    assign rom_addr = sh_load ? '0 : byte_idx + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            byte_idx <= '0;
        else if (sh_load)
            byte_idx <= '0;
        else if (sh_shift && sh_last)
            byte_idx <= byte_idx + 1'b1;
    end

    boot_image_rom #(
        .IMG_BYTES (IMG_BYTES),
        .IDX_W     (IDX_W)
    ) u_rom (
        .addr_i (rom_addr),
        .data_o (rom_data)
    );

    boot_bit_shifter #(
        .W (8)
    ) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .byte_i  (rom_data),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    boot_deadline_timer #(
        .LIMIT_CYC (LIMIT_CYC)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .timeout_o (timeout_o)
    );

    // outputs
    always_comb begin
        dat_o  = 1'b1;
        done_o = 1'b0;
        unique case (state)
            ST_SEND: dat_o  = sh_bit;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    // R8: disable forces the line high and clears done
    a_r8_off_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (dat_o && !done_o));
    // R6: an idle command during streaming aborts to waiting
    a_r6_abort_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state == ST_SEND && is_idle) |=> (state == ST_WAIT && dat_o));
    // R2: streaming is entered only from waiting
    a_r2_start_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_SEND && $past(state) != ST_SEND) |-> ($past(state) == ST_WAIT));
    // R5: completion follows a tick while streaming
    a_r5_done_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(state == ST_SEND && bit_tick_i));
endmodule

// File: tb/sim_boot_streamer_ctrl.sv
module sim_boot_streamer_ctrl;
    localparam int unsigned NB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, vld = 1'b0, tick = 1'b0;
    logic [1:0] code = 2'b00;
    logic       dat, done, tmo;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    boot_streamer_ctrl #(
        .IMG_BYTES   (NB),
        .CLK_HZ      (1000),
        .DEADLINE_MS (200)
    ) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .cmd_valid_i (vld),
        .cmd_code_i  (code),
        .bit_tick_i  (tick),
        .dat_o       (dat),
        .done_o      (done),
        .timeout_o   (tmo)
    );

    // rows: {en, valid, code[1:0], tick, exp_dat, exp_done}
    localparam logic [6:0] VEC [17] = '{
        7'b1_0_00_0_1_0,  // 0 enable
        7'b1_1_01_0_1_0,  // 1 R2 reset-idle ignored
        7'b1_1_10_0_1_0,  // 2 R2 pre-idle ignored
        7'b1_1_00_0_1_0,  // 3 R2 unrecognised ignored
        7'b1_0_11_0_1_0,  // 4 R2 boot code without strobe ignored
        7'b1_1_11_0_1_0,  // 5 R3 start: bit7 of C3
        7'b1_0_00_1_1_0,  // 6 R3 bit6
        7'b1_0_00_1_0_0,  // 7 R3 bit5
        7'b1_0_00_0_0_0,  // 8 R3 hold without tick
        7'b1_1_10_0_1_0,  // 9 R6 pre-idle abort
        7'b1_0_00_1_1_0,  // 10 R6 tick ignored while waiting
        7'b1_1_11_0_1_0,  // 11 R6 restart bit7
        7'b1_0_00_1_1_0,  // 12 R6 bit6
        7'b1_0_00_1_0_0,  // 13 R6 bit5 from byte 0 again
        7'b1_0_00_1_0_0,  // 14 R6 bit4
        7'b1_1_01_0_1_0,  // 15 R6 reset-idle abort
        7'b1_0_00_1_1_0   // 16 R6 still idle
    };

    function automatic logic [7:0] img_byte(int k);
        return 8'((k * 29) % 256) ^ 8'hC3;
    endfunction

    function automatic logic img_bit(int i);
        logic [7:0] b;
        b = img_byte(i / 8);
        return b[7 - (i % 8)];
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic e, logic v, logic [1:0] c, logic t);
        en = e; vld = v; code = c; tick = t;
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0; tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1 dat", dat, 1'b1);
        chk("R1 done", done, 1'b0);
        chk("R1 timeout", tmo, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int r = 0; r < 17; r++) begin
            string tag;
            tag = (r >= 1 && r <= 4) ? "R2" : (r >= 5 && r <= 8) ? "R3" : (r >= 9) ? "R6" : "R1";
            step(VEC[r][6], VEC[r][5], VEC[r][4:3], VEC[r][2]);
            chk({tag, " dat"}, dat, VEC[r][1]);
            chk({tag, " done"}, done, VEC[r][0]);
        end

        // R4 full image, verbatim, MSB first
        step(1'b1, 1'b1, 2'b11, 1'b0);
        for (int i = 0; i < NB * 8; i++) begin
            chk("R4 image bit", dat, img_bit(i));
            step(1'b1, 1'b0, 2'b00, 1'b1);
        end
        chk("R5 done set", done, 1'b1);
        chk("R5 line high", dat, 1'b1);
        step(1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 1'b1, 2'b11, 1'b0);
        chk("R5 boot ignored dat", dat, 1'b1);
        chk("R5 boot ignored done", done, 1'b1);

        // R7 idle clears done, restream
        step(1'b1, 1'b1, 2'b10, 1'b0);
        chk("R7 done cleared", done, 1'b0);
        step(1'b1, 1'b1, 2'b11, 1'b0);
        chk("R7 restart bit7", dat, img_bit(0));
        step(1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 1'b0, 2'b00, 1'b1);
        chk("R7 restart bit5", dat, img_bit(2));

        // R8 disable mid-stream
        step(1'b0, 1'b0, 2'b00, 1'b0);
        chk("R8 dat high", dat, 1'b1);
        chk("R8 done low", done, 1'b0);
        chk("R8 timeout cleared", tmo, 1'b0);
        step(1'b0, 1'b1, 2'b11, 1'b0);
        step(1'b0, 1'b0, 2'b00, 1'b1);
        chk("R8 boot ignored while off", dat, 1'b1);
        step(1'b1, 1'b0, 2'b00, 1'b0);
        step(1'b1, 1'b1, 2'b11, 1'b0);
        step(1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 1'b0, 2'b00, 1'b1);
        chk("R8 fresh start bit5", dat, img_bit(2));

        // R9 deadline: 200 edges with enable high
        step(1'b0, 1'b0, 2'b00, 1'b0);
        for (int k = 0; k < 199; k++) step(1'b1, 1'b0, 2'b00, 1'b0);
        chk("R9 not yet expired", tmo, 1'b0);
        step(1'b1, 1'b0, 2'b00, 1'b0);
        chk("R9 expired", tmo, 1'b1);
        step(1'b1, 1'b0, 2'b00, 1'b0);
        chk("R9 holds", tmo, 1'b1);
        step(1'b0, 1'b0, 2'b00, 1'b0);
        chk("R9 cleared on disable", tmo, 1'b0);

        finish_run();
    end
endmodule